// File: doc/BRIEF.md
# Gear-Down Command Bus Sampler

This block watches the address/command/control bus of a DDR4 memory channel on the rising edges of the memory clock. Its output is the command stream as the memory device itself receives it. After reset it takes a command on every rising edge (1N). Software switches the channel to gear-down operation by writing the enable bit of mode register 3. A single-cycle chip-select pulse then follows to set the phase. From the edge of that pulse onward, the sampler takes commands only on every second rising edge (2N), in step with the pulse.

Each accepted command appears one cycle later as a single-cycle valid strobe, together with the registered command fields. Status outputs report four things: the sampler is waiting for the synchronisation pulse, it is locked in 2N operation, chip select was held too long while waiting, or a command arrived on an off-phase edge.

Top module: `acc_gearsampler`

## Requirements
- R1: After reset the sampler is in 1N operation. `out_vld`, `half_rate`, `wait_sync`, `sync_err` and `off_phase_cmd` are all low.
- R2: In 1N operation, every rising edge with `in_cs_l` low is accepted. In the cycle after that edge, `out_vld` is high and the outputs carry that edge's control bits, group, bank and address. Back-to-back edges give back-to-back commands.
- R3: A mode-register-3 enable write sets `wait_sync` after its edge and leaves `half_rate` low. The write has `in_cs_l`=0, `in_act_l`=1, `in_row_l`=`in_col_l`=`in_wr_l`=0, `in_grp[0]`=0, `in_bank`=2'b11 and `in_adr[3]`=1. The write itself is emitted. While waiting, sampling stays 1N and chip-select edges are still emitted. A mode-register write with another bank value does not start the wait.
- R4: While waiting, a chip-select low lasting exactly one edge that is not a mode-register-3 write is the synchronisation pulse. After the following edge, where `in_cs_l` is high, `half_rate` is high and `wait_sync` is low.
- R5: In 2N operation, the accepted edges are the second, fourth, sixth and so on after the pulse edge. A chip-select command on those edges is emitted.
- R6: In 2N operation, a chip-select low on an off-phase edge is not emitted. `off_phase_cmd` is high for the cycle after that edge.
- R7: While waiting, a chip-select low on two or more consecutive edges raises `sync_err` for one cycle, after the second such edge. It does not lock, the sampler keeps waiting, and a later clean single-edge pulse still locks.
- R8: A mode-register-3 write with `in_adr[3]`=0, taken on an accepted edge, returns the sampler to 1N operation. After it, every edge is sampled again.
- R9: Reset applied in 2N operation returns the sampler to 1N operation and clears the phase lock.
- R10: `out_vld` is high for exactly one cycle per accepted command and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge used |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_cs_l | input | 1 | Chip select, active low |
| in_act_l | input | 1 | Activate control bit, active low |
| in_row_l | input | 1 | Row strobe control bit, active low |
| in_col_l | input | 1 | Column strobe control bit, active low |
| in_wr_l | input | 1 | Write-enable control bit, active low |
| in_grp | input | GRP_W | Bank group |
| in_bank | input | 2 | Bank within group |
| in_adr | input | ADR_W | Address lines |
| out_vld | output | 1 | One-cycle strobe per accepted command |
| out_act_l | output | 1 | Registered activate bit |
| out_row_l | output | 1 | Registered row strobe bit |
| out_col_l | output | 1 | Registered column strobe bit |
| out_wr_l | output | 1 | Registered write-enable bit |
| out_grp | output | GRP_W | Registered bank group |
| out_bank | output | 2 | Registered bank |
| out_adr | output | ADR_W | Registered address |
| half_rate | output | 1 | Locked in 2N operation |
| wait_sync | output | 1 | Enable written, waiting for the pulse |
| sync_err | output | 1 | Chip select held too long while waiting |
| off_phase_cmd | output | 1 | Command seen on an off-phase edge |

## Verification
The assertions check several relations on every cycle. A 1N chip-select edge always produces a strobe. An off-phase flag never coincides with a strobe. Protocol errors occur only while waiting. The wait state is only entered from 1N, the lock only follows a waiting cycle whose edge had chip select high, and the 2N phase alternates on every edge. Only the bench scenarios show the rest: the exact edge on which the lock takes effect, which numbered edges after the pulse are accepted, the once-per-run error pulse, the return to 1N on a disable write or on reset, and the field contents of each emitted command.

// File: rtl/acc_gs_pkg.sv
package acc_gs_pkg;

    typedef enum logic [1:0] {
        RATE_1N   = 2'd0,
        RATE_WAIT = 2'd1,
        RATE_2N   = 2'd2
    } rate_e;

    typedef struct packed {
        logic act_l;
        logic row_l;
        logic col_l;
        logic wr_l;
    } ctl_t;

endpackage

// File: rtl/acc_gs_decode.sv
module acc_gs_decode
    import acc_gs_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              cs_l,
    input  ctl_t              ctl,
    input  logic              grp0,
    input  logic [BANK_W-1:0] bank,
    input  logic              en_bit,
    output logic              sel,
    output logic              mr3_wr,
    output logic              mr3_en
);
    localparam logic [BANK_W-1:0] MR3_BANK = BANK_W'(3);

    logic is_mrs;

    always_comb begin
        sel    = !cs_l;
        is_mrs = ctl.act_l && !ctl.row_l && !ctl.col_l && !ctl.wr_l;
        mr3_wr = sel && is_mrs && !grp0 && (bank == MR3_BANK);
        mr3_en = en_bit;
    end

endmodule

// File: rtl/acc_gs_phase_ctrl.sv
module acc_gs_phase_ctrl
    import acc_gs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel,
    input  logic  mr3_wr,
    input  logic  mr3_en,
    output logic  accept,
    output rate_e rate_q,
    output logic  perr_q,
    output logic  mis_q
);
    typedef struct packed {
        rate_e rate;
        logic  phase;
        logic  cand;
        logic  long_run;
        logic  perr;
        logic  mis;
    } st_t;

    localparam st_t ST_RST = '{rate: RATE_1N, phase: 1'b0, cand: 1'b0,
                               long_run: 1'b0, perr: 1'b0, mis: 1'b0};

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.perr = 1'b0;
        st_d.mis  = 1'b0;
        accept    = (st_q.rate == RATE_2N) ? (sel && st_q.phase) : sel;

        unique case (st_q.rate)
            RATE_1N: begin
                if (accept && mr3_wr && mr3_en) begin
                    st_d.rate     = RATE_WAIT;
                    st_d.cand     = 1'b0;
                    st_d.long_run = 1'b0;
                end
            end
            RATE_WAIT: begin
                if (mr3_wr) begin
                    st_d.rate     = mr3_en ? RATE_WAIT : RATE_1N;
                    st_d.cand     = 1'b0;
                    st_d.long_run = 1'b0;
                end else if (sel) begin
                    if (st_q.cand && !st_q.long_run) begin
                        st_d.perr     = 1'b1;
                        st_d.long_run = 1'b1;
                    end
                    st_d.cand = 1'b1;
                end else begin
                    if (st_q.cand && !st_q.long_run) begin
                        st_d.rate  = RATE_2N;
                        st_d.phase = 1'b1;
                    end
                    st_d.cand     = 1'b0;
                    st_d.long_run = 1'b0;
                end
            end
            RATE_2N: begin
                st_d.phase = !st_q.phase;
                if (sel && !st_q.phase) begin
                    st_d.mis = 1'b1;
                end
                if (accept && mr3_wr && !mr3_en) begin
                    st_d.rate  = RATE_1N;
                    st_d.phase = 1'b0;
                end
            end
            default: st_d = ST_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_q = st_q.rate;
    assign perr_q = st_q.perr;
    assign mis_q  = st_q.mis;

    // R7
    perr_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.perr |-> st_q.rate == RATE_WAIT);

    // R6
    mis_only_geared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mis |-> st_q.rate == RATE_2N);

    // R5
    phase_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rate == RATE_2N && $past(st_q.rate) == RATE_2N && $past(rst_n))
            |-> st_q.phase != $past(st_q.phase));

endmodule

// File: rtl/acc_gs_cmd_reg.sv
module acc_gs_cmd_reg
    import acc_gs_pkg::*;
#(
    parameter int GRP_W  = 2,
    parameter int BANK_W = 2,
    parameter int ADR_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  ctl_t              ctl,
    input  logic [GRP_W-1:0]  grp,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADR_W-1:0]  adr,
    output logic              vld,
    output ctl_t              o_ctl,
    output logic [GRP_W-1:0]  o_grp,
    output logic [BANK_W-1:0] o_bank,
    output logic [ADR_W-1:0]  o_adr
);
    typedef struct packed {
        logic              vld;
        ctl_t              ctl;
        logic [GRP_W-1:0]  grp;
        logic [BANK_W-1:0] bank;
        logic [ADR_W-1:0]  adr;
    } oreg_t;

    oreg_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.vld = accept;
        if (accept) begin
            o_d.ctl  = ctl;
            o_d.grp  = grp;
            o_d.bank = bank;
            o_d.adr  = adr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign vld    = o_q.vld;
    assign o_ctl  = o_q.ctl;
    assign o_grp  = o_q.grp;
    assign o_bank = o_q.bank;
    assign o_adr  = o_q.adr;

    // R10
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_q.vld && $past(rst_n)) |-> $stable(o_q.adr));

endmodule

// File: rtl/acc_gearsampler.sv
module acc_gearsampler
    import acc_gs_pkg::*;
#(
    parameter int GRP_W  = 2,
    parameter int ADR_W  = 17,
    parameter int GD_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_cs_l,
    input  logic             in_act_l,
    input  logic             in_row_l,
    input  logic             in_col_l,
    input  logic             in_wr_l,
    input  logic [GRP_W-1:0] in_grp,
    input  logic [1:0]       in_bank,
    input  logic [ADR_W-1:0] in_adr,
    output logic             out_vld,
    output logic             out_act_l,
    output logic             out_row_l,
    output logic             out_col_l,
    output logic             out_wr_l,
    output logic [GRP_W-1:0] out_grp,
    output logic [1:0]       out_bank,
    output logic [ADR_W-1:0] out_adr,
    output logic             half_rate,
    output logic             wait_sync,
    output logic             sync_err,
    output logic             off_phase_cmd
);
    localparam int BANK_W = 2;

    ctl_t  in_ctl, o_ctl;
    logic  sel, mr3_wr, mr3_en, accept;
    rate_e rate_q;

    assign in_ctl = '{act_l: in_act_l, row_l: in_row_l, col_l: in_col_l, wr_l: in_wr_l};

    acc_gs_decode #(.BANK_W(BANK_W)) i_decode (
        .cs_l   (in_cs_l),
        .ctl    (in_ctl),
        .grp0   (in_grp[0]),
        .bank   (in_bank),
        .en_bit (in_adr[GD_BIT]),
        .sel    (sel),
        .mr3_wr (mr3_wr),
        .mr3_en (mr3_en)
    );

    acc_gs_phase_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .mr3_wr (mr3_wr),
        .mr3_en (mr3_en),
        .accept (accept),
        .rate_q (rate_q),
        .perr_q (sync_err),
        .mis_q  (off_phase_cmd)
    );

    acc_gs_cmd_reg #(.GRP_W(GRP_W), .BANK_W(BANK_W), .ADR_W(ADR_W)) i_oreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .ctl    (in_ctl),
        .grp    (in_grp),
        .bank   (in_bank),
        .adr    (in_adr),
        .vld    (out_vld),
        .o_ctl  (o_ctl),
        .o_grp  (out_grp),
        .o_bank (out_bank),
        .o_adr  (out_adr)
    );

    assign out_act_l = o_ctl.act_l;
    assign out_row_l = o_ctl.row_l;
    assign out_col_l = o_ctl.col_l;
    assign out_wr_l  = o_ctl.wr_l;
    assign half_rate = (rate_q == RATE_2N);
    assign wait_sync = (rate_q == RATE_WAIT);

    // R2
    full_rate_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cs_l && rate_q == RATE_1N) |=> out_vld);

    // R6
    offphase_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_phase_cmd |-> !out_vld);

    // R3
    wait_from_1n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_sync) |-> $past(rate_q) == RATE_1N);

    // R4
    lock_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_rate) |-> ($past(wait_sync) && $past(in_cs_l)));

endmodule

// File: tb/test_acc_gearsampler.sv
module test_acc_gearsampler;
    localparam int GRP_W = 2;
    localparam int ADR_W = 17;

    typedef struct packed {
        logic [3:0]       ctl;
        logic [GRP_W-1:0] grp;
        logic [1:0]       bank;
        logic [ADR_W-1:0] adr;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_cs_l = 1'b1, in_act_l = 1'b1, in_row_l = 1'b1, in_col_l = 1'b1, in_wr_l = 1'b1;
    logic [GRP_W-1:0] in_grp = '0;
    logic [1:0]       in_bank = '0;
    logic [ADR_W-1:0] in_adr = '0;
    logic out_vld, out_act_l, out_row_l, out_col_l, out_wr_l;
    logic [GRP_W-1:0] out_grp;
    logic [1:0]       out_bank;
    logic [ADR_W-1:0] out_adr;
    logic half_rate, wait_sync, sync_err, off_phase_cmd;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    item_t expq[$];

    always #10 clk = ~clk;

    acc_gearsampler #(.GRP_W(GRP_W), .ADR_W(ADR_W)) i_acc_gearsampler (
        .clk(clk), .rst_n(rst_n),
        .in_cs_l(in_cs_l), .in_act_l(in_act_l), .in_row_l(in_row_l),
        .in_col_l(in_col_l), .in_wr_l(in_wr_l),
        .in_grp(in_grp), .in_bank(in_bank), .in_adr(in_adr),
        .out_vld(out_vld), .out_act_l(out_act_l), .out_row_l(out_row_l),
        .out_col_l(out_col_l), .out_wr_l(out_wr_l),
        .out_grp(out_grp), .out_bank(out_bank), .out_adr(out_adr),
        .half_rate(half_rate), .wait_sync(wait_sync),
        .sync_err(sync_err), .off_phase_cmd(off_phase_cmd)
    );

    task automatic chk(input logic cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per emitted command
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            item_t got;
            got = '{ctl: {out_act_l, out_row_l, out_col_l, out_wr_l},
                    grp: out_grp, bank: out_bank, adr: out_adr};
            if (out_vld) begin
                if (expq.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected strobe", 1, 0);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    chk(got == e, cur_req, "command fields", int'(got), int'(e));
                end
            end else if (expq.size() != 0) begin
                void'(expq.pop_front());
                chk(1'b0, cur_req, "missing strobe", 0, 1);
            end
        end
    end

    // Driver: one rising edge per call, returns 3 ns after that edge
    task automatic step(input logic cs, input logic [3:0] c, input logic [GRP_W-1:0] g,
                        input logic [1:0] b, input logic [ADR_W-1:0] a, input logic emit);
        @(negedge clk);
        in_cs_l = cs;
        {in_act_l, in_row_l, in_col_l, in_wr_l} = c;
        in_grp = g; in_bank = b; in_adr = a;
        if (emit) expq.push_back('{ctl: c, grp: g, bank: b, adr: a});
        @(posedge clk);
        #3;
    endtask

    task automatic idle();
        step(1'b1, 4'b1111, '0, '0, '0, 1'b0);
    endtask

    localparam logic [3:0] C_ACT = 4'b0111;
    localparam logic [3:0] C_RD  = 4'b1101;
    localparam logic [3:0] C_NOP = 4'b1111;
    localparam logic [3:0] C_MRS = 4'b1000;

    task automatic flags(input string req, input logic hr, input logic ws,
                         input logic se, input logic mc);
        chk(half_rate == hr, req, "half_rate", int'(half_rate), int'(hr));
        chk(wait_sync == ws, req, "wait_sync", int'(wait_sync), int'(ws));
        chk(sync_err == se, req, "sync_err", int'(sync_err), int'(se));
        chk(off_phase_cmd == mc, req, "off_phase_cmd", int'(off_phase_cmd), int'(mc));
    endtask

    task automatic lock_sequence();
        step(1'b0, C_MRS, 2'b00, 2'b11, 17'h00008, 1'b1);
        idle();
        step(1'b0, C_NOP, '0, '0, 17'h00001, 1'b1);
        idle();
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        // R1 reset state
        cur_req = "R1";
        chk(out_vld == 1'b0, "R1", "out_vld", int'(out_vld), 0);
        flags("R1", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 full-rate sampling, back to back
        cur_req = "R2";
        step(1'b0, C_ACT, 2'b01, 2'b10, 17'h00123, 1'b1);
        step(1'b0, C_RD,  2'b10, 2'b01, 17'h00040, 1'b1);
        step(1'b0, C_RD,  2'b11, 2'b00, 17'h1ffff, 1'b1);
        idle();
        // R10 strobe drops after the command
        cur_req = "R10";
        chk(out_vld == 1'b0, "R10", "strobe after idle", int'(out_vld), 0);

        // R3 mode-register write to another bank does not start the wait
        cur_req = "R3";
        step(1'b0, C_MRS, 2'b00, 2'b10, 17'h00008, 1'b1);
        flags("R3", 0, 0, 0, 0);
        // R3 enable write
        step(1'b0, C_MRS, 2'b00, 2'b11, 17'h00008, 1'b1);
        flags("R3", 0, 1, 0, 0);
        idle();
        flags("R3", 0, 1, 0, 0);

        // R7 long chip-select run
        cur_req = "R7";
        step(1'b0, C_NOP, '0, '0, 17'h00011, 1'b1);
        chk(sync_err == 1'b0, "R7", "no error after first edge", int'(sync_err), 0);
        step(1'b0, C_NOP, '0, '0, 17'h00012, 1'b1);
        chk(sync_err == 1'b1, "R7", "error after second edge", int'(sync_err), 1);
        step(1'b0, C_NOP, '0, '0, 17'h00013, 1'b1);
        chk(sync_err == 1'b0, "R7", "one error per run", int'(sync_err), 0);
        idle();
        flags("R7", 0, 1, 0, 0);

        // R4 clean single-edge pulse, emitted in 1N while waiting
        cur_req = "R4";
        step(1'b0, C_NOP, '0, '0, 17'h00021, 1'b1);
        flags("R4", 0, 1, 0, 0);
        idle();
        flags("R4", 1, 0, 0, 0);

        // R5 / R6 phase of 2N sampling (edges 2,4,6 after pulse are on-phase)
        cur_req = "R5";
        step(1'b0, C_ACT, 2'b01, 2'b01, 17'h00abc, 1'b1);
        cur_req = "R6";
        step(1'b0, C_RD, 2'b10, 2'b10, 17'h00def, 1'b0);
        chk(off_phase_cmd == 1'b1, "R6", "off-phase flag", int'(off_phase_cmd), 1);
        cur_req = "R5";
        step(1'b0, C_RD, 2'b11, 2'b11, 17'h00555, 1'b1);
        chk(off_phase_cmd == 1'b0, "R5", "flag clears on-phase", int'(off_phase_cmd), 0);
        idle();
        step(1'b0, C_ACT, 2'b00, 2'b01, 17'h0aaaa, 1'b1);
        cur_req = "R6";
        step(1'b0, C_NOP, '0, '0, 17'h00077, 1'b0);
        flags("R6", 1, 0, 0, 1);

        // R8 disable write on an on-phase edge
        cur_req = "R8";
        step(1'b0, C_MRS, 2'b00, 2'b11, 17'h00000, 1'b1);
        flags("R8", 0, 0, 0, 0);
        step(1'b0, C_RD, 2'b01, 2'b00, 17'h00101, 1'b1);
        step(1'b0, C_RD, 2'b01, 2'b01, 17'h00102, 1'b1);
        idle();
        flags("R8", 0, 0, 0, 0);

        // R9 reset from 2N
        cur_req = "R9";
        lock_sequence();
        flags("R9", 1, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #3;
        flags("R9", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, C_ACT, 2'b10, 2'b11, 17'h01234, 1'b1);
        step(1'b0, C_RD,  2'b10, 2'b11, 17'h01235, 1'b1);
        idle();
        flags("R9", 0, 0, 0, 0);
        chk(expq.size() == 0, "R10", "queue drained", expq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule